// File: doc/BRIEF.md
# USB Debug Port Scheduler

This block decides when a USB 2.0 debug port may talk to an attached debug console, independently of the regular host controller software. It watches the debug ownership and enable bits, the port status bits (enabled, suspended, reset in progress), the controller run/stop bit and a power-state-D0 flag. From these it derives an operating mode. When the controller is stopped but the port is usable, the block itself must keep the console awake with periodic SYNC-only keepalive packets. When the controller is running, the host's own start-of-frame traffic does that job.

Software asks for a debug transaction through a request flag. The scheduler samples that flag on a fixed poll period and turns each request into a grant, which a downstream packet engine completes with a done strobe. Keepalive requests are handled the same way. A port reset or a suspend/resume sequence blocks new grants until the first start-of-frame that follows it has been sent. Serialization, the PHY and the register bus lie outside the block; they appear only as request/done handshakes.

Top module: `usbdbg_sched`

## Requirements
- R1: `modeOut` decodes combinationally as 0 (unused) when `ownerBit` or `enabledBit` is 0. Otherwise it is 3 (stalled) when `powerD0` is 0, 2 (frame-driven) when `runStop` is 1 regardless of `portEnable`, 1 (keepalive) when `runStop` is 0 and `portEnable` is 1, and 3 when both are 0.
- R2: In mode 1, with the port neither suspended nor in reset, `kaReq` rises exactly every KA_CYC cycles (KA_CYC = CLK_KHZ*KA_US/1000, with KA_US below 2000) while the done strobe returns promptly. Once raised, `kaReq` stays high until `kaDone` is sampled.
- R3: `kaReq` never rises in modes 0, 2 or 3, nor while `portSuspend` or `portReset` is high.
- R4: In modes 1 and 2, `swReq` is sampled every POLL_CYC cycles (POLL_CYC = CLK_KHZ*POLL_US/1000). With nothing blocking, `txGrant` rises 1 to POLL_CYC+1 cycles after `swReq` is raised.
- R5: While `portReset` is high, and afterwards until `sofSent` has been seen, `holdOff` is 1 and no new `txGrant` starts. Grants resume after the first `sofSent`.
- R6: The same hold-off applies to `portSuspend` through the whole suspend/resume sequence until the next `sofSent`.
- R7: A grant already active stays high until `txDone` is sampled, even if a reset or suspend begins.
- R8: `kaReq` and `txGrant` are never high together. A pending keepalive goes first, and a pending transaction is granted in the cycle right after `kaDone` is sampled.
- R9: In modes 0 and 3, no grant and no keepalive is issued, whatever `swReq` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ownerBit | input | 1 | Debug software owns the port |
| enabledBit | input | 1 | Debug function enabled by debug software |
| portEnable | input | 1 | Port enabled in port status/control |
| portSuspend | input | 1 | Port suspended or resuming |
| portReset | input | 1 | Port reset being driven |
| runStop | input | 1 | Host controller running |
| powerD0 | input | 1 | Controller in full-power state |
| sofSent | input | 1 | Start-of-frame packet went out (strobe) |
| swReq | input | 1 | Software debug transaction request |
| kaDone | input | 1 | Keepalive packet finished (strobe) |
| txDone | input | 1 | Debug transaction finished (strobe) |
| kaReq | output | 1 | Request to send a SYNC-only keepalive |
| txGrant | output | 1 | Debug transaction granted |
| holdOff | output | 1 | New debug transactions are blocked |
| modeOut | output | 2 | Current operating mode (see R1) |

## Verification
The hardest case to reach from the ports is a transaction request that is already pending while a keepalive is outstanding. Both timers have to line up, and the keepalive done strobe has to be delayed long enough for a poll to land inside it. The bench holds back `kaDone` by hand after the keepalive rises, raises `swReq` for more than two poll periods, and then releases `kaDone`, so the handover into the grant can be checked in the very next cycle. A second hard case is the hold-off that outlasts the reset or suspend. The bench keeps requests raised across several poll periods after the line condition clears, and only then delivers a start-of-frame strobe.

// File: rtl/usbdbg_pkg.sv
`timescale 1ns/1ps
package usbdbg_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_KEEP  = 2'd1,
    MODE_SOF   = 2'd2,
    MODE_STALL = 2'd3
  } dbgMode_e;

  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_KEEP = 2'd1,
    ARB_XFER = 2'd2
  } arbState_e;

  // control -> timer datapath
  typedef struct packed {
    logic kaRun;
    logic pollRun;
  } timerCtl_t;

  // timer datapath -> control
  typedef struct packed {
    logic kaTick;
    logic pollTick;
  } timerEvt_t;
endpackage

// File: rtl/usbdbg_divider.sv
`timescale 1ns/1ps
module usbdbg_divider #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  output logic tick
);
  localparam int W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] count;

  assign tick = run && (count == LAST);

  always_ff @(posedge clk) begin
    if (!rstN)      count <= '0;
    else if (!run)  count <= '0;
    else if (tick)  count <= '0;
    else            count <= count + 1'b1;
  end
endmodule

// File: rtl/usbdbg_timers.sv
`timescale 1ns/1ps
module usbdbg_timers
  import usbdbg_pkg::*;
#(
  parameter int KA_CYC   = 1000,
  parameter int POLL_CYC = 100
) (
  input  logic      clk,
  input  logic      rstN,
  input  timerCtl_t ctl,
  output timerEvt_t evt
);
  usbdbg_divider #(.LIMIT(KA_CYC)) kaDiv (
    .clk (clk),
    .rstN(rstN),
    .run (ctl.kaRun),
    .tick(evt.kaTick)
  );

  usbdbg_divider #(.LIMIT(POLL_CYC)) pollDiv (
    .clk (clk),
    .rstN(rstN),
    .run (ctl.pollRun),
    .tick(evt.pollTick)
  );
endmodule

// File: rtl/usbdbg_ctrl.sv
`timescale 1ns/1ps
module usbdbg_ctrl
  import usbdbg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ownerBit,
  input  logic       enabledBit,
  input  logic       portEnable,
  input  logic       portSuspend,
  input  logic       portReset,
  input  logic       runStop,
  input  logic       powerD0,
  input  logic       sofSent,
  input  logic       swReq,
  input  logic       kaDone,
  input  logic       txDone,
  input  timerEvt_t  evt,
  output timerCtl_t  ctl,
  output logic       kaReq,
  output logic       txGrant,
  output logic       holdOff,
  output logic [1:0] modeOut
);
  dbgMode_e  mode;
  arbState_e state, nextState;
  logic      holdReg, linkBusy, blocked, live;
  logic      kaPend, txPend, kaWant, canXfer, goKeep, goXfer;

  always_comb begin
    if (!ownerBit || !enabledBit) mode = MODE_OFF;
    else if (!powerD0)            mode = MODE_STALL;
    else if (runStop)             mode = MODE_SOF;
    else if (portEnable)          mode = MODE_KEEP;
    else                          mode = MODE_STALL;
  end

  assign linkBusy    = portReset || portSuspend;
  assign blocked     = holdReg || linkBusy;
  assign live        = (mode == MODE_KEEP) || (mode == MODE_SOF);
  assign ctl.kaRun   = (mode == MODE_KEEP) && !linkBusy;
  assign ctl.pollRun = live;

  // hold-off lasts through reset/suspend and until the first frame after it
  always_ff @(posedge clk) begin
    if (!rstN)         holdReg <= 1'b0;
    else if (linkBusy) holdReg <= 1'b1;
    else if (sofSent)  holdReg <= 1'b0;
  end

  assign kaWant  = ctl.kaRun && (kaPend || evt.kaTick);
  assign canXfer = live && txPend && !blocked;

  always_comb begin
    nextState = state;
    unique case (state)
      ARB_IDLE: begin
        if (kaWant)       nextState = ARB_KEEP;
        else if (canXfer) nextState = ARB_XFER;
      end
      ARB_KEEP: begin
        if (kaDone) nextState = canXfer ? ARB_XFER : ARB_IDLE;
      end
      ARB_XFER: begin
        if (txDone) nextState = ARB_IDLE;
      end
      default: nextState = ARB_IDLE;
    endcase
  end

  assign goKeep = (state == ARB_IDLE) && (nextState == ARB_KEEP);
  assign goXfer = (state != ARB_XFER) && (nextState == ARB_XFER);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ARB_IDLE;
      kaPend <= 1'b0;
      txPend <= 1'b0;
    end else begin
      state <= nextState;
      if (!ctl.kaRun)  kaPend <= 1'b0;
      else if (goKeep) kaPend <= 1'b0;
      else if (evt.kaTick) kaPend <= 1'b1;
      if (!live)       txPend <= 1'b0;
      else if (goXfer) txPend <= 1'b0;
      else if (evt.pollTick && swReq) txPend <= 1'b1;
    end
  end

  assign kaReq   = (state == ARB_KEEP);
  assign txGrant = (state == ARB_XFER);
  assign holdOff = blocked;
  assign modeOut = mode;
endmodule

// File: rtl/usbdbg_sched.sv
`timescale 1ns/1ps
module usbdbg_sched
  import usbdbg_pkg::*;
#(
  parameter int CLK_KHZ = 60000,
  parameter int KA_US   = 1000,
  parameter int POLL_US = 100
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ownerBit,
  input  logic       enabledBit,
  input  logic       portEnable,
  input  logic       portSuspend,
  input  logic       portReset,
  input  logic       runStop,
  input  logic       powerD0,
  input  logic       sofSent,
  input  logic       swReq,
  input  logic       kaDone,
  input  logic       txDone,
  output logic       kaReq,
  output logic       txGrant,
  output logic       holdOff,
  output logic [1:0] modeOut
);
  localparam int KA_CYC   = CLK_KHZ * KA_US / 1000;
  localparam int POLL_CYC = CLK_KHZ * POLL_US / 1000;

  timerCtl_t tCtl;
  timerEvt_t tEvt;

  usbdbg_timers #(.KA_CYC(KA_CYC), .POLL_CYC(POLL_CYC)) timers (
    .clk (clk),
    .rstN(rstN),
    .ctl (tCtl),
    .evt (tEvt)
  );

  usbdbg_ctrl ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ownerBit   (ownerBit),
    .enabledBit (enabledBit),
    .portEnable (portEnable),
    .portSuspend(portSuspend),
    .portReset  (portReset),
    .runStop    (runStop),
    .powerD0    (powerD0),
    .sofSent    (sofSent),
    .swReq      (swReq),
    .kaDone     (kaDone),
    .txDone     (txDone),
    .evt        (tEvt),
    .ctl        (tCtl),
    .kaReq      (kaReq),
    .txGrant    (txGrant),
    .holdOff    (holdOff),
    .modeOut    (modeOut)
  );
endmodule

// File: rtl/usbdbg_sched_chk.sv
`timescale 1ns/1ps
module usbdbg_sched_chk (
  input logic       clk,
  input logic       rstN,
  input logic       portSuspend,
  input logic       portReset,
  input logic       kaDone,
  input logic       txDone,
  input logic       kaReq,
  input logic       txGrant,
  input logic       holdOff,
  input logic [1:0] modeOut
);
  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(kaReq && txGrant));

  assert_grant_unblocked_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txGrant) |-> !$past(holdOff));

  assert_grant_live_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txGrant) |-> ($past(modeOut) == 2'd1 || $past(modeOut) == 2'd2));

  assert_keep_mode_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(kaReq) |-> ($past(modeOut) == 2'd1 && !$past(portSuspend) && !$past(portReset)));

  assert_grant_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    (txGrant && !txDone) |=> txGrant);

  assert_keep_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    (kaReq && !kaDone) |=> kaReq);

  assert_reset_blocks_R5: assert property (@(posedge clk) disable iff (!rstN)
    portReset |=> holdOff);

  assert_suspend_blocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    portSuspend |=> holdOff);
endmodule

bind usbdbg_sched usbdbg_sched_chk chk (
  .clk        (clk),
  .rstN       (rstN),
  .portSuspend(portSuspend),
  .portReset  (portReset),
  .kaDone     (kaDone),
  .txDone     (txDone),
  .kaReq      (kaReq),
  .txGrant    (txGrant),
  .holdOff    (holdOff),
  .modeOut    (modeOut)
);

// File: tb/usbdbg_sched_test.sv
`timescale 1ns/1ps
module usbdbg_sched_test;
  localparam int CLK_KHZ  = 100;
  localparam int KA_US    = 1000;
  localparam int POLL_US  = 100;
  localparam int KA_CYC   = CLK_KHZ * KA_US / 1000;
  localparam int POLL_CYC = CLK_KHZ * POLL_US / 1000;

  logic clk = 1'b0;
  logic rstN, ownerBit, enabledBit, portEnable, portSuspend, portReset;
  logic runStop, powerD0, sofSent, swReq, kaDone, txDone;
  logic kaReq, txGrant, holdOff;
  logic [1:0] modeOut;

  int checks = 0, errors = 0, cyc = 0;
  int kaRiseAll = 0, grantRiseAll = 0, lastRise = -1, kaRises = 0;
  bit measureKa = 0, autoKa = 1, autoTx = 1, prevKa = 0, prevTx = 0, done = 0;

  always #10 clk = ~clk;

  usbdbg_sched #(.CLK_KHZ(CLK_KHZ), .KA_US(KA_US), .POLL_US(POLL_US)) uut (
    .clk(clk), .rstN(rstN), .ownerBit(ownerBit), .enabledBit(enabledBit),
    .portEnable(portEnable), .portSuspend(portSuspend), .portReset(portReset),
    .runStop(runStop), .powerD0(powerD0), .sofSent(sofSent), .swReq(swReq),
    .kaDone(kaDone), .txDone(txDone), .kaReq(kaReq), .txGrant(txGrant),
    .holdOff(holdOff), .modeOut(modeOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // one clock: sample at the falling edge, then drive responder strobes
  task automatic step();
    @(negedge clk);
    cyc++;
    if (kaReq && txGrant) check(0, "R8", 2, 1);
    if (kaReq && !prevKa) begin
      kaRiseAll++;
      if (measureKa) begin
        if (lastRise >= 0) check(cyc - lastRise == KA_CYC, "R2", cyc - lastRise, KA_CYC);
        lastRise = cyc;
        kaRises++;
      end
    end
    if (txGrant && !prevTx) grantRiseAll++;
    prevKa = kaReq;
    prevTx = txGrant;
    kaDone = autoKa ? (kaReq && !kaDone) : 1'b0;
    txDone = autoTx ? (txGrant && !txDone) : 1'b0;
    sofSent = 1'b0;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic waitGrant(input int limit, output int n);
    n = 0;
    while (!txGrant && n < limit) begin step(); n++; end
  endtask

  task automatic pulseSof();
    sofSent = 1'b1;
    step();
  endtask

  function automatic int expMode(bit o, bit e, bit pe, bit rs, bit d0);
    if (!o || !e) return 0;
    if (!d0) return 3;
    if (rs) return 2;
    if (pe) return 1;
    return 3;
  endfunction

  task automatic setMode(bit o, bit e, bit pe, bit rs, bit d0);
    ownerBit = o; enabledBit = e; portEnable = pe; runStop = rs; powerD0 = d0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, base, gbase, bad;
    rstN = 0; setMode(0, 0, 0, 0, 0);
    portSuspend = 0; portReset = 0; sofSent = 0; swReq = 0; kaDone = 0; txDone = 0;
    steps(3);
    check(!kaReq && !txGrant, "R1 reset kaReq/txGrant", {kaReq, txGrant}, 0);
    check(modeOut == 2'd0, "R1 reset mode", modeOut, 0);
    rstN = 1;
    step();

    // R1: full sweep of the five mode bits
    for (int v = 0; v < 32; v++) begin
      setMode(v[0], v[1], v[2], v[3], v[4]);
      #1;
      check(modeOut == 2'(expMode(v[0], v[1], v[2], v[3], v[4])), "R1",
            modeOut, expMode(v[0], v[1], v[2], v[3], v[4]));
      step();
    end

    // R2: keepalive cadence in mode 1
    setMode(1, 1, 1, 0, 1);
    steps(2);
    measureKa = 1; lastRise = -1; kaRises = 0;
    steps(4 * KA_CYC + 4);
    measureKa = 0;
    check(kaRises >= 4, "R2 keepalive count", kaRises, 4);

    // R3: no keepalive in frame-driven mode or while suspended
    setMode(1, 1, 1, 1, 1);
    steps(3);
    base = kaRiseAll;
    steps(3 * KA_CYC);
    check(kaRiseAll == base, "R3 mode2", kaRiseAll - base, 0);
    setMode(1, 1, 1, 0, 1);
    portSuspend = 1;
    steps(3);
    base = kaRiseAll;
    steps(3 * KA_CYC);
    check(kaRiseAll == base, "R3 suspended", kaRiseAll - base, 0);

    // R6: suspend hold-off in mode 2
    setMode(1, 1, 1, 1, 1);
    swReq = 1;
    gbase = grantRiseAll;
    steps(3 * POLL_CYC);
    check(holdOff == 1'b1, "R6 holdOff during suspend", holdOff, 1);
    portSuspend = 0;
    steps(3 * POLL_CYC);
    check(holdOff == 1'b1, "R6 holdOff before frame", holdOff, 1);
    check(grantRiseAll == gbase, "R6 no grant", grantRiseAll - gbase, 0);
    pulseSof();
    check(holdOff == 1'b0, "R6 holdOff after frame", holdOff, 0);
    waitGrant(POLL_CYC + 3, n);
    check(txGrant == 1'b1, "R6 grant after frame", txGrant, 1);
    swReq = 0;
    steps(4);

    // R5: port reset hold-off
    portReset = 1;
    swReq = 1;
    gbase = grantRiseAll;
    steps(3 * POLL_CYC);
    check(holdOff == 1'b1, "R5 holdOff during reset", holdOff, 1);
    portReset = 0;
    steps(3 * POLL_CYC);
    check(grantRiseAll == gbase, "R5 no grant", grantRiseAll - gbase, 0);
    check(holdOff == 1'b1, "R5 holdOff before frame", holdOff, 1);
    pulseSof();
    waitGrant(POLL_CYC + 3, n);
    check(txGrant == 1'b1, "R5 grant after frame", txGrant, 1);
    swReq = 0;
    steps(4);

    // R4: poll latency from several phases
    for (int k = 0; k < 4; k++) begin
      steps(k * 3 + 1);
      swReq = 1;
      waitGrant(POLL_CYC + 4, n);
      check(n >= 1 && n <= POLL_CYC + 1, "R4 latency", n, POLL_CYC + 1);
      swReq = 0;
      steps(3);
    end

    // R7: in-flight grant survives a reset
    autoTx = 0;
    swReq = 1;
    waitGrant(POLL_CYC + 4, n);
    check(txGrant == 1'b1, "R7 granted", txGrant, 1);
    swReq = 0;
    portReset = 1;
    bad = 0;
    for (int i = 0; i < 20; i++) begin step(); if (!txGrant) bad++; end
    check(bad == 0, "R7 grant held", bad, 0);
    txDone = 1;
    step();
    check(txGrant == 1'b0, "R7 grant ends on done", txGrant, 0);
    portReset = 0;
    step();
    pulseSof();
    autoTx = 1;

    // R8: keepalive first, grant right after its done strobe
    setMode(1, 1, 1, 0, 1);
    autoKa = 0;
    n = 0;
    while (!kaReq && n < KA_CYC + 3) begin step(); n++; end
    check(kaReq == 1'b1, "R8 keepalive raised", kaReq, 1);
    swReq = 1;
    steps(2 * POLL_CYC + 2);
    check(kaReq == 1'b1 && txGrant == 1'b0, "R8 grant waits", txGrant, 0);
    kaDone = 1;
    step();
    check(txGrant == 1'b1 && kaReq == 1'b0, "R8 handover", txGrant, 1);
    swReq = 0;
    autoKa = 1;
    steps(4);

    // R9: nothing issued when unused or out of D0
    setMode(0, 1, 1, 0, 1);
    swReq = 1;
    steps(2);
    base = kaRiseAll; gbase = grantRiseAll;
    steps(3 * POLL_CYC);
    check(grantRiseAll == gbase && kaRiseAll == base, "R9 unused",
          grantRiseAll - gbase + kaRiseAll - base, 0);
    setMode(1, 1, 1, 0, 0);
    steps(2);
    base = kaRiseAll; gbase = grantRiseAll;
    steps(KA_CYC + 5);
    check(modeOut == 2'd3, "R9 stalled mode", modeOut, 3);
    check(grantRiseAll == gbase && kaRiseAll == base, "R9 stalled",
          grantRiseAll - gbase + kaRiseAll - base, 0);
    swReq = 0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule